// File: doc/BRIEF.md
# I2C Bit-Rate Prescaler with Rate Search

This block produces the pacing tick for an I2C bus engine from the system clock. A 7-bit rate code holds a multiplier field M in bits [6:3] and an exponent field N in bits [2:0]. The resulting SCL rate is the system clock divided by 10·(M+1)·2^(N+1). The tick pulses ten times per SCL period, so the engine can place its bus edges on a grid of tenths.

A parameter selects a second divide law that uses 2^N in place of 2^(N+1).

The block also contains a rate finder. It takes a requested SCL frequency in hertz and works through all 128 field pairs, one per clock, with the exponent as the slow index and the multiplier as the fast index. It keeps the fastest rate that is not above the request. When it finishes, it reports that rate and its code, and it loads the code into the rate register. If no pair is slow enough, the rate register takes the code 0x44, which is also its reset value, and the reported rate is 0.

Top module: `i2c_rate_gen`

## Requirements
- R1: After reset the rate code reads 0x44, the finder is not busy and the done pulse is low.
- R2: With EXP_OFF=1 (default), the tick is high for one clock out of every (M+1)·2^(N+1) clocks, where M is code bits [6:3] and N is code bits [2:0].
- R3: A rate code write restarts the divider. The first tick appears in the P-th clock after the write edge, where P is the new period.
- R4: The finder returns the highest rate sysclk/(10·(M+1)·2^(N+1)), rounded down, that does not exceed the request. Among equal rates, the pair met first wins: N from 0 to 7 in the outer loop, M from 0 to 15 in the inner loop, and the code is M·8+N.
- R5: When every candidate rate exceeds the request, the finder returns code 0x44 and rate 0.
- R6: The finder raises done for one clock, exactly 128 clocks after the edge that accepted the start, and it is busy in between.
- R7: A start pulse while the finder is busy is ignored. The running search keeps its request and its finishing time.
- R8: On the clock after done, the rate register holds the found code and the divider restarts, so the first tick follows P clocks after that load.
- R9: With EXP_OFF=0, the tick period is (M+1)·2^N clocks, which is one clock for code 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the rate code |
| cfg_code | input | 7 | Rate code to write, M in [6:3] and N in [2:0] |
| search_go | input | 1 | Start a rate search |
| search_req_hz | input | 32 | Requested SCL frequency in hertz |
| baud_code | output | 7 | Current rate code |
| scl_tick | output | 1 | Pacing tick, ten per SCL period |
| search_busy | output | 1 | Search in progress |
| search_done | output | 1 | One-clock pulse at search end |
| search_hz | output | 32 | Rate found, valid with done |
| search_code | output | 7 | Code found, valid with done |

## Verification
The hardest case to reach is a tie: two field pairs that give the same rounded rate. Only the scan order decides which one wins. The stimulus requests exactly 2.5 MHz, which is reached both by M=1,N=0 and by M=0,N=1. The expected code 0x08 is checked by name.

A start pulse is injected partway through a search to show that the running search keeps its request and its finishing time. A request below the slowest possible rate drives the finder into its no-match path.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;

    localparam int FLD_M_W    = 4;
    localparam int FLD_N_W    = 3;
    localparam int CODE_W     = FLD_M_W + FLD_N_W;
    localparam int HZ_W       = 32;
    localparam int M_COUNT    = 1 << FLD_M_W;
    localparam int PAIR_COUNT = 1 << CODE_W;
    localparam int BIT_SLOTS  = 10;
    localparam logic [CODE_W-1:0] RESET_CODE = 7'h44;

    typedef struct packed {
        logic [FLD_M_W-1:0] m;
        logic [FLD_N_W-1:0] n;
    } rate_code_t;

    function automatic int unsigned base_rate(input int unsigned sys_hz,
                                              input int unsigned m_val);
        return sys_hz / (BIT_SLOTS * (m_val + 1));
    endfunction

endpackage

// File: rtl/i2c_rate_prescale.sv
module i2c_rate_prescale
    import i2c_rate_pkg::*;
#(
    parameter int EXP_OFF = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart_i,
    input  rate_code_t code_i,
    output logic       tick_o
);
    localparam int POST_W = (1 << FLD_N_W) - 1 + EXP_OFF;

    logic [FLD_M_W-1:0] pre_cnt;
    logic [POST_W-1:0]  post_cnt;
    logic [POST_W-1:0]  post_last;
    logic               pre_end;
    logic               post_end;

    always_comb begin
        post_last = POST_W'((32'd1 << (int'(code_i.n) + EXP_OFF)) - 32'd1);
        pre_end   = (pre_cnt == code_i.m);
        post_end  = (post_cnt == post_last);
    end

    assign tick_o = pre_end && post_end;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            pre_cnt  <= '0;
            post_cnt <= '0;
        end else if (pre_end) begin
            pre_cnt  <= '0;
            post_cnt <= post_end ? '0 : post_cnt + 1'b1;
        end else begin
            pre_cnt  <= pre_cnt + 1'b1;
        end
    end

    // R2
    pre_range_chk: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= code_i.m);

    // R2
    post_range_chk: assert property (@(posedge clk) disable iff (rst)
        post_cnt <= post_last);

    generate
        if (EXP_OFF > 0) begin : g_gap
            // R2
            tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/i2c_rate_search.sv
module i2c_rate_search
    import i2c_rate_pkg::*;
#(
    parameter int unsigned SYS_HZ  = 100_000_000,
    parameter int          EXP_OFF = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [HZ_W-1:0]   req_hz_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [HZ_W-1:0]   hz_o,
    output rate_code_t        code_o
);
    localparam logic [CODE_W-1:0] LAST_IDX = CODE_W'(PAIR_COUNT - 1);

    logic [HZ_W-1:0]    rate_tab [M_COUNT];
    logic [CODE_W-1:0]  idx;
    logic [HZ_W-1:0]    req_q;
    logic [HZ_W-1:0]    best_hz;
    rate_code_t         best_code;
    rate_code_t         cand;
    logic [HZ_W-1:0]    cand_hz;
    logic               take;

    generate
        for (genvar g = 0; g < M_COUNT; g++) begin : g_tab
            assign rate_tab[g] = HZ_W'(base_rate(SYS_HZ, g));
        end
    endgenerate

    always_comb begin
        cand    = rate_code_t'({idx[FLD_M_W-1:0], idx[CODE_W-1:FLD_M_W]});
        cand_hz = rate_tab[cand.m] >> (int'(cand.n) + EXP_OFF);
        take    = (cand_hz <= req_q) && (cand_hz > best_hz);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            idx       <= '0;
            req_q     <= '0;
            best_hz   <= '0;
            best_code <= rate_code_t'(RESET_CODE);
        end else begin
            done_o <= 1'b0;
            if (!busy_o) begin
                if (start_i) begin
                    busy_o    <= 1'b1;
                    idx       <= '0;
                    req_q     <= req_hz_i;
                    best_hz   <= '0;
                    best_code <= rate_code_t'(RESET_CODE);
                end
            end else begin
                if (take) begin
                    best_hz   <= cand_hz;
                    best_code <= cand;
                end
                idx <= idx + 1'b1;
                if (idx == LAST_IDX) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign hz_o   = best_hz;
    assign code_o = best_code;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy_o) && !busy_o));

    // R4
    not_faster_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (hz_o <= req_q));

    // R5
    no_match_code_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && hz_o == '0) |-> (code_o == rate_code_t'(RESET_CODE)));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(req_q));

endmodule

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen
    import i2c_rate_pkg::*;
#(
    parameter int unsigned SYS_HZ  = 100_000_000,
    parameter int          EXP_OFF = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [6:0]  cfg_code,
    input  logic        search_go,
    input  logic [31:0] search_req_hz,
    output logic [6:0]  baud_code,
    output logic        scl_tick,
    output logic        search_busy,
    output logic        search_done,
    output logic [31:0] search_hz,
    output logic [6:0]  search_code
);
    rate_code_t code_q;
    rate_code_t found_code;
    logic       reload;

    assign reload = search_done || cfg_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= rate_code_t'(RESET_CODE);
        end else if (search_done) begin
            code_q <= found_code;
        end else if (cfg_we) begin
            code_q <= rate_code_t'(cfg_code);
        end
    end

    i2c_rate_search #(
        .SYS_HZ  (SYS_HZ),
        .EXP_OFF (EXP_OFF)
    ) u_search (
        .clk      (clk),
        .rst      (rst),
        .start_i  (search_go),
        .req_hz_i (search_req_hz),
        .busy_o   (search_busy),
        .done_o   (search_done),
        .hz_o     (search_hz),
        .code_o   (found_code)
    );

    i2c_rate_prescale #(
        .EXP_OFF (EXP_OFF)
    ) u_prescale (
        .clk       (clk),
        .rst       (rst),
        .restart_i (reload),
        .code_i    (code_q),
        .tick_o    (scl_tick)
    );

    assign baud_code   = code_q;
    assign search_code = found_code;

    // R8
    load_found_chk: assert property (@(posedge clk) disable iff (rst)
        search_done |=> (baud_code == $past(search_code)));

    // R3
    write_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !search_done) |=> (baud_code == $past(cfg_code)));

endmodule

// File: tb/tb_i2c_rate_gen.sv
module tb_i2c_rate_gen;
    localparam int CLK_NS = 10;
    localparam longint SYS = 100_000_000;

    typedef struct {
        logic [6:0] code;
        longint     hz;
        longint     done_at;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_code = '0;
    logic        search_go = 1'b0;
    logic [31:0] search_req_hz = '0;
    logic [6:0]  baud_code, search_code, alt_code, alt_scode;
    logic        scl_tick, search_busy, search_done;
    logic        alt_tick, alt_busy, alt_done;
    logic [31:0] search_hz, alt_hz;
    logic        use_alt = 1'b0;
    logic        cur_tick;

    int     n_checks = 0;
    int     n_errors = 0;
    longint edges = 0;
    exp_t   sb_q[$];

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) edges <= edges + 1;
    assign cur_tick = use_alt ? alt_tick : scl_tick;

    i2c_rate_gen dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_code(cfg_code),
        .search_go(search_go), .search_req_hz(search_req_hz),
        .baud_code(baud_code), .scl_tick(scl_tick), .search_busy(search_busy),
        .search_done(search_done), .search_hz(search_hz), .search_code(search_code)
    );

    i2c_rate_gen #(.EXP_OFF(0)) dut_alt (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_code(cfg_code),
        .search_go(1'b0), .search_req_hz(32'd0),
        .baud_code(alt_code), .scl_tick(alt_tick), .search_busy(alt_busy),
        .search_done(alt_done), .search_hz(alt_hz), .search_code(alt_scode)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint period_of(input logic [6:0] c, input int off);
        return (longint'(c[6:3]) + 1) << (int'(c[2:0]) + off);
    endfunction

    function automatic void ref_search(input longint req, output logic [6:0] code,
                                       output longint hz);
        hz = 0;
        code = 7'h44;
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 16; m++) begin
                longint f;
                f = SYS / (10 * (m + 1) * (longint'(1) << (n + 1)));
                if (f <= req && f > hz) begin
                    hz = f;
                    code = 7'((m << 3) | n);
                end
            end
        end
    endfunction

    // count samples until tick; sample 1 is the first negedge already taken
    task automatic count_to_tick(output longint cnt);
        cnt = 1;
        while (!cur_tick && cnt < 10000) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    task automatic write_and_time(input logic [6:0] c, input int off, input string req);
        longint first, per;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_code = c;
        @(negedge clk);
        cfg_we = 1'b0;
        count_to_tick(first);
        chk(first == period_of(c, off), req, first, period_of(c, off));
        @(negedge clk);
        count_to_tick(per);
        chk(per == period_of(c, off), req, per, period_of(c, off));
    endtask

    // driver: pushes the expected result, then starts the search and waits
    task automatic run_search(input longint req, input bit poke, input bit time_tick);
        exp_t e;
        longint t;
        ref_search(req, e.code, e.hz);
        @(negedge clk);
        e.done_at = edges + 129;
        sb_q.push_back(e);
        search_go = 1'b1;
        search_req_hz = 32'(req);
        @(negedge clk);
        search_go = 1'b0;
        chk(search_busy == 1'b1, "R6 busy", search_busy, 1);
        if (poke) begin
            repeat (10) @(negedge clk);
            search_go = 1'b1;
            search_req_hz = 32'd5_000_000;
            @(negedge clk);
            search_go = 1'b0;
        end
        while (!search_done && edges < e.done_at + 5) @(negedge clk);
        @(negedge clk);
        chk(baud_code == e.code, "R8 code loaded", baud_code, e.code);
        chk(search_busy == 1'b0, "R7 no restart", search_busy, 0);
        if (time_tick) begin
            count_to_tick(t);
            chk(t == period_of(e.code, 1), "R8 restart", t, period_of(e.code, 1));
        end
    endtask

    // monitor: pops and compares when the design reports a result
    always @(negedge clk) begin
        if (!rst && search_done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7 extra done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(search_code == e.code, "R4 code", search_code, e.code);
                chk(longint'(search_hz) == e.hz, "R4 rate", search_hz, e.hz);
                chk(edges == e.done_at, "R6 done time", edges, e.done_at);
            end
        end
    end

    initial begin
        #(CLK_NS * 150000);
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", edges, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        longint per;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(baud_code == 7'h44, "R1 code", baud_code, 'h44);
        chk(search_busy == 1'b0, "R1 busy", search_busy, 0);
        chk(search_done == 1'b0, "R1 done", search_done, 0);

        // R2 reset code period 9*32
        while (!scl_tick) @(negedge clk);
        @(negedge clk);
        count_to_tick(per);
        chk(per == 288, "R2 reset period", per, 288);

        write_and_time(7'h00, 1, "R3 code00");
        write_and_time(7'h13, 1, "R2 code13");
        write_and_time(7'h7A, 1, "R3 code7A");

        use_alt = 1'b1;
        write_and_time(7'h00, 0, "R9 code00");
        write_and_time(7'h13, 0, "R9 code13");
        use_alt = 1'b0;

        run_search(100_000, 1'b0, 1'b1);
        run_search(2_500_000, 1'b0, 1'b0);
        chk(search_code == 7'h08, "R4 tie", search_code, 'h08);
        run_search(1000, 1'b0, 1'b0);
        chk(search_code == 7'h44 && search_hz == 0, "R5 no match", search_code, 'h44);
        run_search(64'd4_000_000_000, 1'b0, 1'b1);
        run_search(33_333, 1'b1, 1'b0);
        run_search(400_000, 1'b0, 1'b1);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R6 all done", sb_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule